// File: doc/BRIEF.md
# Receiver Idle Watchdog

This block watches a serial receiver's character FIFO and raises a sticky timeout flag once the receive line has been quiet for more than 64 bit times while characters are still waiting. It exists for the tail of a message. A last few characters can sit below the FIFO fill threshold and never trigger the level interrupt. This watchdog makes sure the host still comes to collect them.

The block counts bit-time ticks from the baud logic. Any FIFO activity restarts the count. A character written into the FIFO is activity. So is a host read through either of two read paths: the per-channel path or the shared global path. When the count passes the limit, the flag sets and a one-cycle expiry pulse is emitted. The counter then saturates, so a single idle period gives a single expiry. Any later read through either path clears the flag. An interrupt request is presented only while the mask input is high. The counter stays at zero while the FIFO is empty or the block is disabled.

Top module: `rx_idle_watchdog`

## Requirements
- R1: After reset, `wd_flag`, `wd_expire` and `wd_irq` are all 0.
- R2: A cycle with `fifo_load`, `host_rd` or `global_rd` high restarts the idle count at zero. After such a cycle, 64 further ticks do not set the flag.
- R3: With `enable` high, the FIFO not empty and no FIFO activity, `wd_flag` becomes 1 on the clock edge that takes the 65th `bit_tick` since the count was last zero. It is still 0 after 64 ticks.
- R4: While `fifo_not_empty` is 0 the count holds at zero, so any number of ticks gives no timeout.
- R5: A cycle with `host_rd` or `global_rd` high clears `wd_flag` on the following edge.
- R6: `wd_expire` is high for exactly one cycle, on the edge where `wd_flag` sets. After that the count saturates, and continued idle ticks give no further expiry until FIFO activity occurs.
- R7: While `enable` is 0 the count holds at zero and no timeout occurs.
- R8: `wd_irq` is high exactly when `wd_flag` is 1 and `wd_mask` is 1.
- R9: A read in the same cycle as the 65th tick wins: the flag stays 0 and no expiry pulse is produced.
- R10: A `fifo_load` with no read in the same cycle leaves a set `wd_flag` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Watchdog enable; 0 holds the count at zero |
| bit_tick | input | 1 | One-cycle pulse per receiver bit time |
| fifo_load | input | 1 | A received character is written into the FIFO this cycle |
| host_rd | input | 1 | Host read through the per-channel read path |
| global_rd | input | 1 | Host read through the shared global read path |
| fifo_not_empty | input | 1 | FIFO holds at least one character |
| wd_mask | input | 1 | Interrupt mask for the timeout source |
| wd_flag | output | 1 | Sticky timeout status |
| wd_expire | output | 1 | One-cycle pulse when the timeout fires |
| wd_irq | output | 1 | Masked interrupt request |

## Verification
On every cycle, the assertions check that activity, an empty FIFO or a disable leave the count at zero on the next edge. They also check that a saturated count stays put, that a read always leaves the flag clear, that a lone load keeps it set, and that the expiry pulse lasts one cycle and comes with a set flag. The exact tick on which the flag rises (the 65th and not the 64th), a read racing the expiry tick, and the absence of a second expiry over a long idle stretch can only be shown by the bench's scenarios against its reference model.

// File: rtl/rxwd_pkg.sv
// Shared definitions for the receiver idle watchdog.
// Assumes all strobes are single-cycle, synchronous to the block clock.
package rxwd_pkg;
    localparam int unsigned DEF_IDLE_LIMIT = 64;

    // FIFO activity strobes gathered into one bundle.
    typedef struct packed {
        logic load;
        logic rd_local;
        logic rd_global;
    } rx_fifo_act_t;
endpackage

// File: rtl/rxwd_activity.sv
// Merges the FIFO activity strobes into "any activity" and "any read".
// Assumes the strobes are already synchronous; purely combinational.
module rxwd_activity
    import rxwd_pkg::*;
(
    input  rx_fifo_act_t act,
    output logic         any_act,
    output logic         any_read
);
    // Combine: any strobe restarts the count, only reads clear the flag.
    always_comb begin
        any_read = act.rd_local | act.rd_global;
        any_act  = any_read | act.load;
    end
endmodule

// File: rtl/rxwd_idle_counter.sv
// Counts bit ticks while the FIFO is non-empty and idle. It fires on the
// tick that moves the count from IDLE_LIMIT to IDLE_LIMIT+1, then saturates.
// Assumes bit_tick is a one-cycle pulse.
module rxwd_idle_counter #(
    parameter int unsigned IDLE_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_tick,
    input  logic any_act,
    input  logic not_empty,
    output logic fire
);
    localparam int unsigned SAT_VAL = IDLE_LIMIT + 1;
    localparam int unsigned CNT_W   = $clog2(IDLE_LIMIT + 2);
    localparam logic [CNT_W-1:0] SAT_C   = CNT_W'(SAT_VAL);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(IDLE_LIMIT);

    logic [CNT_W-1:0] cnt_q;
    logic             run;

    // Counting allowed only when enabled, holding data and quiet.
    always_comb begin
        run  = enable & not_empty & ~any_act;
        fire = run & bit_tick & (cnt_q == LIMIT_C);
    end

    // Idle count: restart on activity or empty/disable, saturate past limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (bit_tick && cnt_q != SAT_C)
            cnt_q <= cnt_q + 1'b1;
    end

    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        any_act |=> (cnt_q == '0));
    a_r4_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !not_empty |=> (cnt_q == '0));
    a_r7_disable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt_q == '0));
    a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == SAT_C && run) |=> (cnt_q == SAT_C));
endmodule

// File: rtl/rxwd_flag_ctl.sv
// Holds the sticky timeout flag and the one-cycle expiry pulse.
// A read clears the flag and takes priority over a coincident fire.
module rxwd_flag_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic any_read,
    input  logic load,
    output logic flag,
    output logic expire
);
    // Flag set on fire, cleared by either read path.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (any_read)
            flag <= 1'b0;
        else if (fire)
            flag <= 1'b1;
    end

    // Expiry pulse registered alongside the flag rise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            expire <= 1'b0;
        else
            expire <= fire & ~any_read;
    end

    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        any_read |=> !flag);
    a_r10_load_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && load && !any_read) |=> flag);
    a_r6_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);
    a_r3_pulse_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> flag);
endmodule

// File: rtl/rx_idle_watchdog.sv
// Receiver idle watchdog top: activity merge, idle counter, flag control
// and interrupt masking. Assumes the FIFO and baud tick live outside.
module rx_idle_watchdog
    import rxwd_pkg::*;
#(
    parameter int unsigned IDLE_LIMIT = DEF_IDLE_LIMIT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_tick,
    input  logic fifo_load,
    input  logic host_rd,
    input  logic global_rd,
    input  logic fifo_not_empty,
    input  logic wd_mask,
    output logic wd_flag,
    output logic wd_expire,
    output logic wd_irq
);
    rx_fifo_act_t act;
    logic         any_act;
    logic         any_read;
    logic         fire;

    // Bundle the strobes for the merge stage.
    always_comb begin
        act.load      = fifo_load;
        act.rd_local  = host_rd;
        act.rd_global = global_rd;
    end

    rxwd_activity u_act (
        .act      (act),
        .any_act  (any_act),
        .any_read (any_read)
    );

    rxwd_idle_counter #(.IDLE_LIMIT(IDLE_LIMIT)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .bit_tick  (bit_tick),
        .any_act   (any_act),
        .not_empty (fifo_not_empty),
        .fire      (fire)
    );

    rxwd_flag_ctl u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .any_read (any_read),
        .load     (fifo_load),
        .flag     (wd_flag),
        .expire   (wd_expire)
    );

    // Interrupt request only while the source is unmasked.
    always_comb wd_irq = wd_flag & wd_mask;

    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_flag |-> !wd_irq);
endmodule

// File: tb/tb_rx_idle_watchdog.sv
module tb_rx_idle_watchdog;
    localparam int CLK_PERIOD = 10;
    localparam int LIM = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, bit_tick = 1'b0, fifo_load = 1'b0;
    logic host_rd = 1'b0, global_rd = 1'b0, fifo_not_empty = 1'b0, wd_mask = 1'b0;
    logic wd_flag, wd_expire, wd_irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;
    int expire_seen = 0;

    // Reference model state
    int m_cnt = 0;
    bit m_flag = 1'b0;
    bit m_exp = 1'b0;

    rx_idle_watchdog dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .bit_tick(bit_tick),
        .fifo_load(fifo_load), .host_rd(host_rd), .global_rd(global_rd),
        .fifo_not_empty(fifo_not_empty), .wd_mask(wd_mask),
        .wd_flag(wd_flag), .wd_expire(wd_expire), .wd_irq(wd_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model updated at every edge, compared shortly after.
    always @(posedge clk) begin
        bit rd, ev, go;
        cycles++;
        rd = host_rd | global_rd;
        ev = rd | fifo_load;
        if (!rst_n) begin
            m_cnt = 0; m_flag = 0; m_exp = 0;
        end else begin
            go = enable && fifo_not_empty && !ev && bit_tick && (m_cnt == LIM);
            m_exp = go;
            if (rd) m_flag = 0;
            if (go) m_flag = 1;
            if (ev || !fifo_not_empty || !enable) m_cnt = 0;
            else if (bit_tick && m_cnt <= LIM) m_cnt++;
        end
        #3;
        if (!done) begin
            chk(wd_flag == m_flag, "model flag (R3)", wd_flag, m_flag);
            chk(wd_expire == m_exp, "model expire (R6)", wd_expire, m_exp);
            chk(wd_irq == (m_flag & wd_mask), "model irq (R8)", wd_irq, m_flag & wd_mask);
            if (wd_expire) expire_seen++;
        end
    end

    // Watchdog for a hung run.
    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // n ticks, each followed by gap idle cycles.
    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1;
            step();
            bit_tick = 1'b0;
            for (int g = 0; g < gap; g++) step();
        end
    endtask

    task automatic pulse_load();
        fifo_load = 1'b1; step(); fifo_load = 1'b0;
    endtask

    task automatic pulse_rd(input bit global);
        if (global) global_rd = 1'b1; else host_rd = 1'b1;
        step();
        host_rd = 1'b0; global_rd = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) step();
        // R1: reset state
        chk(wd_flag == 0, "R1 flag", wd_flag, 0);
        chk(wd_expire == 0, "R1 expire", wd_expire, 0);
        chk(wd_irq == 0, "R1 irq", wd_irq, 0);
        rst_n = 1'b1;
        enable = 1'b1; wd_mask = 1'b1;
        fifo_not_empty = 1'b1;
        pulse_load();

        // R3: 64 ticks no flag, 65th sets it
        ticks(LIM, 0);
        chk(wd_flag == 0, "R3 after 64", wd_flag, 0);
        ticks(1, 0);
        chk(wd_flag == 1, "R3 after 65", wd_flag, 1);
        chk(wd_expire == 1, "R6 pulse", wd_expire, 1);
        chk(wd_irq == 1, "R8 unmasked", wd_irq, 1);
        step();
        chk(wd_expire == 0, "R6 pulse end", wd_expire, 0);
        wd_mask = 1'b0; #1;
        chk(wd_irq == 0, "R8 masked", wd_irq, 0);
        wd_mask = 1'b1;

        // R6: long idle gives no second expiry
        expire_seen = 0;
        ticks(200, 0);
        chk(expire_seen == 0, "R6 no repeat", expire_seen, 0);

        // R10: load keeps flag; R5: local read clears
        pulse_load();
        chk(wd_flag == 1, "R10 load keeps", wd_flag, 1);
        pulse_rd(1'b0);
        chk(wd_flag == 0, "R5 local read", wd_flag, 0);

        // R2: restart mid-count by load (slow ticks)
        ticks(40, 2);
        pulse_load();
        ticks(LIM, 2);
        chk(wd_flag == 0, "R2 restart load", wd_flag, 0);
        ticks(1, 0);
        chk(wd_flag == 1, "R2 then fire", wd_flag, 1);
        pulse_rd(1'b1);
        chk(wd_flag == 0, "R5 global read", wd_flag, 0);

        // R2: restart by global read
        ticks(50, 1);
        pulse_rd(1'b1);
        ticks(LIM, 0);
        chk(wd_flag == 0, "R2 restart read", wd_flag, 0);
        pulse_rd(1'b0);

        // R4: empty FIFO never times out
        fifo_not_empty = 1'b0;
        ticks(150, 0);
        chk(wd_flag == 0, "R4 empty", wd_flag, 0);
        fifo_not_empty = 1'b1;
        ticks(LIM, 0);
        chk(wd_flag == 0, "R4 count from zero", wd_flag, 0);
        pulse_rd(1'b0);

        // R7: disabled never times out
        enable = 1'b0;
        ticks(150, 0);
        chk(wd_flag == 0, "R7 disabled", wd_flag, 0);
        enable = 1'b1;
        pulse_load();

        // R9: read on the 65th tick wins
        ticks(LIM, 0);
        expire_seen = 0;
        bit_tick = 1'b1; host_rd = 1'b1;
        step();
        bit_tick = 1'b0; host_rd = 1'b0;
        chk(wd_flag == 0, "R9 race flag", wd_flag, 0);
        chk(expire_seen == 0, "R9 race expire", expire_seen, 0);
        ticks(LIM, 0);
        chk(wd_flag == 0, "R9 restarted", wd_flag, 0);
        ticks(1, 0);
        chk(wd_flag == 1, "R9 later fire", wd_flag, 1);

        step();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule